// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block drives a design whose flip-flops are joined into mux-type scan chains. It applies a fixed set of combinational test vectors. For each vector it first holds the test-control line low for as many cycles as the longest chain has bits, shifting state into every chain in parallel. It then raises the line for one capture cycle. In that cycle it also drives the primary inputs of the vector. The captured state is shifted out while the next vector's state is shifted in. After the last vector, one further shift pass unloads the last capture. A run of V vectors over chains of at most N bits therefore takes exactly (V+1)·N + V cycles.

Load words, primary-input words, expected responses and don't-care masks are constant parameter arrays inside the block. The block compares each unloaded scan bit against its expected value in the cycle the bit appears, and does the same for the primary outputs in the capture cycle. It raises a sticky fail flag and records the index of the first failing vector. For partial scan it drives two clock enables: one for the scanned flip-flops and one for the non-scanned flip-flops.

Top module: `scan_vec_seq`

## Requirements
- R1: After reset the block is idle: test_ctl, scan_clk_en, func_clk_en, done and fail are 0, fail_vec is 0, and scan_in and prim_in are all zero.
- R2: A start seen while idle begins a run in the next cycle. Each vector gets SHIFT_LEN shift cycles (test_ctl=0) followed by one capture cycle (test_ctl=1). After the last vector come SHIFT_LEN more shift cycles. done is high for exactly one cycle, the cycle that follows the run's final shift cycle, so it is the (NUM_VEC+1)·SHIFT_LEN+NUM_VEC-th cycle after the accepting edge.
- R3: In shift cycle k (k = 0 first) of loading vector v, scan_in[c] carries bit SHIFT_LEN-1-k of chain c's load word. Load bit j ends in chain position j, and position 0 is next to the serial input, so the top bits of the word for a shorter chain are leading pad. During the final unload pass scan_in is all zero. The load bit for vector v, chain c, position j is LOAD_ROM[(v·NUM_CHAINS+c)·SHIFT_LEN+j].
- R4: prim_in carries PI_ROM[v·NUM_PI +: NUM_PI] in the capture cycle of vector v and is zero in every other cycle.
- R5: scan_clk_en is high in every shift and capture cycle of a run. func_clk_en is high only in capture cycles. Both are low while idle.
- R6: In shift cycle k of any pass except the first load, scan_out[c] is compared with bit k of the previous vector's expected word. That bit is EXP_SO[(v·NUM_CHAINS+c)·SHIFT_LEN+k], and the comparison counts only where the same bit of MASK_SO is 1. scan_out is not compared during the load of vector 0.
- R7: In the capture cycle of vector v, prim_out is compared with EXP_PO[v·NUM_PO +: NUM_PO] wherever MASK_PO is 1.
- R8: A mismatch sets fail at the clock edge that ends the mismatching cycle. fail_vec then holds the index of that vector. Both stay unchanged until the next accepted start, even if later vectors also mismatch.
- R9: A start seen while a run is in progress is ignored. The run keeps its length and no second run follows.
- R10: An accepted start clears fail and fail_vec, so both read 0 in the first cycle of the new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| scan_out | input | NUM_CHAINS | Serial outputs of the scan chains |
| prim_out | input | NUM_PO | Primary outputs of the design under test |
| test_ctl | output | 1 | 0 = shift mode, 1 = normal (capture) mode |
| scan_clk_en | output | 1 | Clock enable for scanned flip-flops |
| func_clk_en | output | 1 | Clock enable for non-scanned flip-flops |
| scan_in | output | NUM_CHAINS | Serial inputs of the scan chains |
| prim_in | output | NUM_PI | Primary inputs applied at capture |
| done | output | 1 | One-cycle pulse after the final unload |
| fail | output | 1 | Sticky mismatch flag |
| fail_vec | output | $clog2(NUM_VEC+1) | Index of the first failing vector |

## Verification
Counting cycles from the edge that accepts start, cycle i of a run lies between that edge plus i and plus i+1. Vector v occupies cycles v·(SHIFT_LEN+1) to v·(SHIFT_LEN+1)+SHIFT_LEN, and done falls in cycle (NUM_VEC+1)·SHIFT_LEN+NUM_VEC. test_ctl, both clock enables, scan_in and prim_in change in the same cycle as the state that produces them. A mismatch in cycle i shows on fail in cycle i+1. After each accepting edge the scoreboard queues one expected control word per cycle, and the monitor pops one word at every falling edge. The fail flag is sampled in the cycle just before the predicted set point and in the cycle of it, using faults placed in an unload bit and in a primary output of chosen vectors.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SHIFT   = 2'd1,
        PH_CAPTURE = 2'd2
    } phase_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
`timescale 1ns/1ps
// Phase and counter sequencing: SHIFT_LEN shift cycles, one capture, repeated,
// then a final unload pass.
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NUM_VEC   = 3,
    parameter int SHIFT_LEN = 4,
    localparam int VEC_W = $clog2(NUM_VEC + 1),
    localparam int BIT_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_e           phase_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             accept_o,
    output logic             done_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SHIFT_LEN - 1);
    localparam logic [VEC_W-1:0] VEC_END  = VEC_W'(NUM_VEC);

    typedef struct packed {
        phase_e           phase;
        logic [VEC_W-1:0] vec;
        logic [BIT_W-1:0] bit_n;
        logic             done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctrl_d.phase = PH_SHIFT;
                    ctrl_d.vec   = '0;
                    ctrl_d.bit_n = '0;
                end
            end
            PH_SHIFT: begin
                if (ctrl_q.bit_n == LAST_BIT) begin
                    ctrl_d.bit_n = '0;
                    if (ctrl_q.vec == VEC_END) begin
                        ctrl_d.phase = PH_IDLE;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.phase = PH_CAPTURE;
                    end
                end else begin
                    ctrl_d.bit_n = ctrl_q.bit_n + 1'b1;
                end
            end
            PH_CAPTURE: begin
                ctrl_d.phase = PH_SHIFT;
                ctrl_d.vec   = ctrl_q.vec + 1'b1;
            end
            default: ctrl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, vec: '0, bit_n: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign phase_o  = ctrl_q.phase;
    assign vec_o    = ctrl_q.vec;
    assign bit_o    = ctrl_q.bit_n;
    assign accept_o = (ctrl_q.phase == PH_IDLE) && start;
    assign done_o   = ctrl_q.done;

    // Length of the current run of consecutive shift cycles, kept for checks only.
    logic [BIT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (ctrl_q.phase == PH_SHIFT) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_shift_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_CAPTURE) |-> (run_q == (BIT_W+1)'(SHIFT_LEN)))
        else $error("capture not preceded by a full shift pass");

    assert_done_after_unload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |-> (run_q == (BIT_W+1)'(SHIFT_LEN)) && (ctrl_q.phase == PH_IDLE))
        else $error("done without a completed final unload");

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done)
        else $error("done longer than one cycle");

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase != PH_IDLE) |=> !($past(ctrl_q.phase) != PH_IDLE && ctrl_q.phase == PH_SHIFT
                                         && ctrl_q.vec == '0 && ctrl_q.bit_n == '0))
        else $error("run restarted while busy");
endmodule

// File: rtl/scan_seq_rom.sv
`timescale 1ns/1ps
// Constant pattern storage and read selection.
module scan_seq_rom #(
    parameter int NUM_VEC    = 3,
    parameter int NUM_CHAINS = 2,
    parameter int SHIFT_LEN  = 4,
    parameter int NUM_PI     = 2,
    parameter int NUM_PO     = 2,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] LOAD_ROM = '0,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] EXP_SO   = '0,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] MASK_SO  = '0,
    parameter logic [NUM_VEC*NUM_PI-1:0]               PI_ROM   = '0,
    parameter logic [NUM_VEC*NUM_PO-1:0]               EXP_PO   = '0,
    parameter logic [NUM_VEC*NUM_PO-1:0]               MASK_PO  = '0,
    localparam int VEC_W = $clog2(NUM_VEC + 1),
    localparam int BIT_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1
) (
    input  logic                  load_act,
    input  logic                  capture_act,
    input  logic [VEC_W-1:0]      vec,
    input  logic [VEC_W-1:0]      unload_vec,
    input  logic [BIT_W-1:0]      bit_idx,
    output logic [NUM_CHAINS-1:0] scan_in,
    output logic [NUM_CHAINS-1:0] exp_so,
    output logic [NUM_CHAINS-1:0] mask_so,
    output logic [NUM_PI-1:0]     prim_in,
    output logic [NUM_PO-1:0]     exp_po,
    output logic [NUM_PO-1:0]     mask_po
);
    localparam int VEC_SLOTS = 1 << VEC_W;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SHIFT_LEN - 1);

    logic [SHIFT_LEN-1:0] load_w [VEC_SLOTS][NUM_CHAINS];
    logic [SHIFT_LEN-1:0] exp_w  [VEC_SLOTS][NUM_CHAINS];
    logic [SHIFT_LEN-1:0] msk_w  [VEC_SLOTS][NUM_CHAINS];
    logic [NUM_PI-1:0]    pi_w   [VEC_SLOTS];
    logic [NUM_PO-1:0]    epo_w  [VEC_SLOTS];
    logic [NUM_PO-1:0]    mpo_w  [VEC_SLOTS];

    // Unused index slots read as zero with a zero mask.
    for (genvar v = 0; v < VEC_SLOTS; v++) begin : g_slot
        if (v < NUM_VEC) begin : g_used
            for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
                assign load_w[v][c] = LOAD_ROM[(v*NUM_CHAINS + c)*SHIFT_LEN +: SHIFT_LEN];
                assign exp_w[v][c]  = EXP_SO[(v*NUM_CHAINS + c)*SHIFT_LEN +: SHIFT_LEN];
                assign msk_w[v][c]  = MASK_SO[(v*NUM_CHAINS + c)*SHIFT_LEN +: SHIFT_LEN];
            end
            assign pi_w[v]  = PI_ROM[v*NUM_PI +: NUM_PI];
            assign epo_w[v] = EXP_PO[v*NUM_PO +: NUM_PO];
            assign mpo_w[v] = MASK_PO[v*NUM_PO +: NUM_PO];
        end else begin : g_spare
            for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
                assign load_w[v][c] = '0;
                assign exp_w[v][c]  = '0;
                assign msk_w[v][c]  = '0;
            end
            assign pi_w[v]  = '0;
            assign epo_w[v] = '0;
            assign mpo_w[v] = '0;
        end
    end

    // Highest word bit goes out first so bit j settles in chain position j.
    logic [BIT_W-1:0] rev_idx;
    assign rev_idx = LAST_BIT - bit_idx;

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_out
        assign scan_in[c] = load_act & load_w[vec][c][rev_idx];
        assign exp_so[c]  = exp_w[unload_vec][c][bit_idx];
        assign mask_so[c] = msk_w[unload_vec][c][bit_idx];
    end

    assign prim_in = capture_act ? pi_w[vec] : '0;
    assign exp_po  = epo_w[vec];
    assign mask_po = mpo_w[vec];
endmodule

// File: rtl/scan_seq_cmp.sv
`timescale 1ns/1ps
// Masked response comparison with sticky first-failure capture.
module scan_seq_cmp #(
    parameter int NUM_CHAINS = 2,
    parameter int NUM_PO     = 2,
    parameter int VEC_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  unload_act,
    input  logic                  capture_act,
    input  logic [VEC_W-1:0]      unload_vec,
    input  logic [VEC_W-1:0]      capture_vec,
    input  logic [NUM_CHAINS-1:0] scan_out,
    input  logic [NUM_CHAINS-1:0] exp_so,
    input  logic [NUM_CHAINS-1:0] mask_so,
    input  logic [NUM_PO-1:0]     prim_out,
    input  logic [NUM_PO-1:0]     exp_po,
    input  logic [NUM_PO-1:0]     mask_po,
    output logic                  fail,
    output logic [VEC_W-1:0]      fail_vec
);
    typedef struct packed {
        logic             fail;
        logic [VEC_W-1:0] vec;
    } cmp_s;

    cmp_s cmp_d, cmp_q;
    logic so_bad, po_bad;

    always_comb begin
        so_bad = unload_act  && (|((scan_out ^ exp_so) & mask_so));
        po_bad = capture_act && (|((prim_out ^ exp_po) & mask_po));
        cmp_d  = cmp_q;
        if (clear) begin
            cmp_d.fail = 1'b0;
            cmp_d.vec  = '0;
        end else if (!cmp_q.fail && (so_bad || po_bad)) begin
            cmp_d.fail = 1'b1;
            cmp_d.vec  = po_bad ? capture_vec : unload_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '{fail: 1'b0, vec: '0};
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign fail     = cmp_q.fail;
    assign fail_vec = cmp_q.vec;

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q.fail && !clear) |=> cmp_q.fail)
        else $error("fail flag dropped without a start");

    assert_first_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q.fail && !clear) |=> $stable(cmp_q.vec))
        else $error("first failing index overwritten");

    assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!cmp_q.fail && cmp_q.vec == '0))
        else $error("start did not clear the result");
endmodule

// File: rtl/scan_vec_seq.sv
`timescale 1ns/1ps
module scan_vec_seq
    import scan_seq_pkg::*;
#(
    parameter int NUM_VEC    = 3,
    parameter int NUM_CHAINS = 2,
    parameter int SHIFT_LEN  = 4,
    parameter int NUM_PI     = 2,
    parameter int NUM_PO     = 2,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] LOAD_ROM = '0,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] EXP_SO   = '0,
    parameter logic [NUM_VEC*NUM_CHAINS*SHIFT_LEN-1:0] MASK_SO  = '0,
    parameter logic [NUM_VEC*NUM_PI-1:0]               PI_ROM   = '0,
    parameter logic [NUM_VEC*NUM_PO-1:0]               EXP_PO   = '0,
    parameter logic [NUM_VEC*NUM_PO-1:0]               MASK_PO  = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [NUM_CHAINS-1:0]            scan_out,
    input  logic [NUM_PO-1:0]                prim_out,
    output logic                             test_ctl,
    output logic                             scan_clk_en,
    output logic                             func_clk_en,
    output logic [NUM_CHAINS-1:0]            scan_in,
    output logic [NUM_PI-1:0]                prim_in,
    output logic                             done,
    output logic                             fail,
    output logic [$clog2(NUM_VEC+1)-1:0]     fail_vec
);
    localparam int VEC_W = $clog2(NUM_VEC + 1);
    localparam int BIT_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;
    localparam logic [VEC_W-1:0] VEC_END = VEC_W'(NUM_VEC);

    phase_e           phase;
    logic [VEC_W-1:0] vec, unload_vec;
    logic [BIT_W-1:0] bit_idx;
    logic             accept;
    logic             load_act, unload_act, capture_act;
    logic [NUM_CHAINS-1:0] exp_so, mask_so;
    logic [NUM_PO-1:0]     exp_po, mask_po;

    scan_seq_ctrl #(
        .NUM_VEC   (NUM_VEC),
        .SHIFT_LEN (SHIFT_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .phase_o  (phase),
        .vec_o    (vec),
        .bit_o    (bit_idx),
        .accept_o (accept),
        .done_o   (done)
    );

    assign load_act    = (phase == PH_SHIFT) && (vec != VEC_END);
    assign unload_act  = (phase == PH_SHIFT) && (vec != '0);
    assign capture_act = (phase == PH_CAPTURE);
    assign unload_vec  = vec - VEC_W'(1);

    assign test_ctl    = capture_act;
    assign scan_clk_en = (phase != PH_IDLE);
    assign func_clk_en = capture_act;

    scan_seq_rom #(
        .NUM_VEC    (NUM_VEC),
        .NUM_CHAINS (NUM_CHAINS),
        .SHIFT_LEN  (SHIFT_LEN),
        .NUM_PI     (NUM_PI),
        .NUM_PO     (NUM_PO),
        .LOAD_ROM   (LOAD_ROM),
        .EXP_SO     (EXP_SO),
        .MASK_SO    (MASK_SO),
        .PI_ROM     (PI_ROM),
        .EXP_PO     (EXP_PO),
        .MASK_PO    (MASK_PO)
    ) u_rom (
        .load_act    (load_act),
        .capture_act (capture_act),
        .vec         (vec),
        .unload_vec  (unload_vec),
        .bit_idx     (bit_idx),
        .scan_in     (scan_in),
        .exp_so      (exp_so),
        .mask_so     (mask_so),
        .prim_in     (prim_in),
        .exp_po      (exp_po),
        .mask_po     (mask_po)
    );

    scan_seq_cmp #(
        .NUM_CHAINS (NUM_CHAINS),
        .NUM_PO     (NUM_PO),
        .VEC_W      (VEC_W)
    ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .unload_act  (unload_act),
        .capture_act (capture_act),
        .unload_vec  (unload_vec),
        .capture_vec (vec),
        .scan_out    (scan_out),
        .exp_so      (exp_so),
        .mask_so     (mask_so),
        .prim_out    (prim_out),
        .exp_po      (exp_po),
        .mask_po     (mask_po),
        .fail        (fail),
        .fail_vec    (fail_vec)
    );

    assert_func_en_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        func_clk_en |-> (scan_clk_en && test_ctl))
        else $error("functional clock enable outside capture");

    assert_prim_in_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !test_ctl |-> (prim_in == '0))
        else $error("primary inputs driven outside capture");

    assert_final_pass_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_clk_en && !test_ctl && vec == VEC_END) |-> (scan_in == '0))
        else $error("nonzero scan input during final unload");
endmodule

// File: tb/scan_vec_seq_bench.sv
`timescale 1ns/1ps
module scan_vec_seq_bench;
    localparam int V    = 3;
    localparam int C    = 2;
    localparam int N    = 4;
    localparam int NPI  = 2;
    localparam int NPO  = 2;
    localparam int VW   = $clog2(V + 1);
    localparam int BITS = V * C * N;
    localparam int T    = (V + 1) * N + V;

    // Model of the design under test: chain 0 has 4 bits, chain 1 has 3,
    // plus one non-scanned flip-flop. Result bits: n0[3:0], n1[6:4], ns[7], po[9:8].
    function automatic logic [9:0] f_cap(input logic [3:0] s0, input logic [2:0] s1,
                                         input logic ns, input logic [1:0] pi);
        logic [3:0] n0;
        logic [2:0] n1;
        logic [1:0] po;
        n0 = {s0[3]^s1[0]^pi[1], s0[2]^s1[2]^pi[0], s0[1]^s1[1]^pi[1], s0[0]^s1[0]^pi[0]};
        n1 = {s0[3]^pi[1], s0[2]&s1[1], s0[1]|ns};
        po = {(s0[3]&pi[1])|s1[0], s0[0]^s1[2]^ns};
        return {po, ns^s1[1]^pi[0], n1, n0};
    endfunction

    function automatic logic [BITS-1:0] gen_load();
        logic [BITS-1:0] r;
        for (int b = 0; b < BITS; b++) r[b] = (((b*5 + 3) % 7) < 3);
        // Pad bit of the short chain set to 1 so its masked unload slot differs from 0.
        for (int v = 0; v < V; v++) r[(v*C + 1)*N + 3] = 1'b1;
        return r;
    endfunction

    function automatic logic [V*NPI-1:0] gen_pi();
        logic [V*NPI-1:0] r;
        for (int v = 0; v < V; v++) r[v*NPI +: NPI] = NPI'(v + 1);
        return r;
    endfunction

    function automatic logic [BITS-1:0] gen_mask_so();
        logic [BITS-1:0] r;
        r = '1;
        for (int v = 0; v < V; v++) r[(v*C + 1)*N + 3] = 1'b0;
        return r;
    endfunction

    function automatic logic [BITS+V*NPO-1:0] gen_exp(input logic [BITS-1:0] ld,
                                                      input logic [V*NPI-1:0] pw);
        logic [BITS-1:0]  so;
        logic [V*NPO-1:0] po;
        logic [9:0]       r;
        logic             ns;
        so = '0; po = '0; ns = 1'b0;
        for (int v = 0; v < V; v++) begin
            r = f_cap(ld[(v*C)*N +: 4], ld[(v*C + 1)*N +: 3], ns, pw[v*NPI +: NPI]);
            for (int k = 0; k < 4; k++) so[(v*C)*N + k] = r[3 - k];
            for (int k = 0; k < 3; k++) so[(v*C + 1)*N + k] = r[6 - k];
            po[v*NPO +: NPO] = r[9:8];
            ns = r[7];
        end
        return {po, so};
    endfunction

    localparam logic [BITS-1:0]      LOAD_P = gen_load();
    localparam logic [V*NPI-1:0]     PI_P   = gen_pi();
    localparam logic [BITS-1:0]      MSO_P  = gen_mask_so();
    localparam logic [BITS+V*NPO-1:0] EXP_ALL = gen_exp(LOAD_P, PI_P);
    localparam logic [BITS-1:0]      ESO_P  = EXP_ALL[BITS-1:0];
    localparam logic [V*NPO-1:0]     EPO_P  = EXP_ALL[BITS +: V*NPO];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [C-1:0]   scan_out;
    logic [NPO-1:0] prim_out;
    logic test_ctl, scan_clk_en, func_clk_en, done, fail;
    logic [C-1:0]   scan_in;
    logic [NPI-1:0] prim_in;
    logic [VW-1:0]  fail_vec;

    always #10 clk = ~clk;

    scan_vec_seq #(
        .NUM_VEC (V), .NUM_CHAINS (C), .SHIFT_LEN (N), .NUM_PI (NPI), .NUM_PO (NPO),
        .LOAD_ROM (LOAD_P), .EXP_SO (ESO_P), .MASK_SO (MSO_P),
        .PI_ROM (PI_P), .EXP_PO (EPO_P), .MASK_PO ('1)
    ) u_scan_vec_seq (
        .clk (clk), .rst_n (rst_n), .start (start),
        .scan_out (scan_out), .prim_out (prim_out),
        .test_ctl (test_ctl), .scan_clk_en (scan_clk_en), .func_clk_en (func_clk_en),
        .scan_in (scan_in), .prim_in (prim_in),
        .done (done), .fail (fail), .fail_vec (fail_vec)
    );

    // Design-under-test model with fault injection by capture number.
    logic [3:0] m0;
    logic [2:0] m1;
    logic       mns;
    int         mcap;
    logic       mclr = 1'b0;
    int         inj_so = -1;
    int         inj_po = -1;
    logic [9:0] mr;

    assign mr       = f_cap(m0, m1, mns, prim_in);
    assign scan_out = {m1[2], m0[3]};
    assign prim_out = mr[9:8] ^ {1'b0, (mcap == inj_po)};

    always_ff @(posedge clk) begin
        if (mclr) begin
            m0 <= 4'hF; m1 <= 3'h7; mns <= 1'b0; mcap <= 0;
        end else begin
            if (scan_clk_en) begin
                if (!test_ctl) begin
                    m0 <= {m0[2:0], scan_in[0]};
                    m1 <= {m1[1:0], scan_in[1]};
                end else begin
                    m0 <= mr[3:0] ^ {(mcap == inj_so), 3'b000};
                    m1 <= mr[6:4];
                end
            end
            if (func_clk_en) begin
                mns  <= mr[7];
                mcap <= mcap + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic           tc;
        logic           sce;
        logic           fce;
        logic           dn;
        logic           sin_chk;
        logic [C-1:0]   sin;
        logic [NPI-1:0] pi;
    } item_t;

    item_t sb_q[$];
    item_t mon_it;

    // Monitor: one expected control word per cycle, compared at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            chk("R2 test_ctl", 32'(test_ctl), 32'(mon_it.tc));
            chk("R5 scan_clk_en", 32'(scan_clk_en), 32'(mon_it.sce));
            chk("R5 func_clk_en", 32'(func_clk_en), 32'(mon_it.fce));
            chk("R2 done", 32'(done), 32'(mon_it.dn));
            chk("R4 prim_in", 32'(prim_in), 32'(mon_it.pi));
            if (mon_it.sin_chk) chk("R3 scan_in", 32'(scan_in), 32'(mon_it.sin));
        end
    end

    // Driver: queue the expected word for each cycle 0..T of a run.
    task automatic push_run();
        item_t it;
        for (int i = 0; i <= T; i++) begin
            int v = i / (N + 1);
            int k = i % (N + 1);
            it = '0;
            if (i == T) begin
                it.dn = 1'b1;
            end else if (v < V && k == N) begin
                it.tc = 1'b1; it.sce = 1'b1; it.fce = 1'b1;
                it.pi = PI_P[v*NPI +: NPI];
            end else begin
                it.sce = 1'b1; it.sin_chk = 1'b1;
                for (int c = 0; c < C; c++)
                    it.sin[c] = (v < V) ? LOAD_P[(v*C + c)*N + (N - 1 - k)] : 1'b0;
            end
            sb_q.push_back(it);
        end
    endtask

    task automatic run_seq(input int so_f, input int po_f, input bit mid_start,
                           input int fail_cyc, input int exp_idx);
        inj_so = so_f;
        inj_po = po_f;
        @(negedge clk); mclr = 1'b1;
        @(negedge clk); mclr = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        push_run();
        for (int i = 0; i <= T + 1; i++) begin
            @(negedge clk);
            if (i == 0) begin
                chk("R10 fail cleared", 32'(fail), 32'd0);
                chk("R10 fail_vec cleared", 32'(fail_vec), 32'd0);
            end
            if (fail_cyc >= 0 && i == fail_cyc - 1) chk("R8 fail before edge", 32'(fail), 32'd0);
            if (fail_cyc >= 0 && i == fail_cyc)     chk("R8 fail set", 32'(fail), 32'd1);
            if (i == T) begin
                chk("R6 R7 R8 fail at done", 32'(fail), 32'(fail_cyc >= 0));
                chk("R8 first failing vector", 32'(fail_vec), 32'(exp_idx));
            end
            if (i == T + 1) begin
                chk("R9 idle after run", 32'(scan_clk_en), 32'd0);
                chk("R2 done single", 32'(done), 32'd0);
            end
            if (mid_start && i == 7) start = 1'b1;
            if (mid_start && i == 8) start = 1'b0;
        end
    endtask

    initial begin
        #55;
        chk("R1 test_ctl in reset", 32'(test_ctl), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scan_clk_en", 32'(scan_clk_en), 32'd0);
        chk("R1 func_clk_en", 32'(func_clk_en), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 fail", 32'(fail), 32'd0);
        chk("R1 fail_vec", 32'(fail_vec), 32'd0);
        chk("R1 scan_in", 32'(scan_in), 32'd0);
        chk("R1 prim_in", 32'(prim_in), 32'd0);
        // Clean run with a start pulse while busy: no fail, masked pad bits ignored.
        run_seq(-1, -1, 1'b1, -1, 0);
        // Unload fault on vector 1 (seen in cycle 10), later output fault on vector 2.
        run_seq(1, 2, 1'b0, 11, 1);
        // Primary-output fault on vector 0 (capture cycle 4).
        run_seq(-1, 0, 1'b0, 5, 0);
        // Unload fault on the last vector, found in the final unload pass (cycle 15).
        run_seq(2, -1, 1'b0, 16, 2);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule